// File: doc/BRIEF.md
# DMA Line-Splitting Request Sequencer

This block takes one DMA transfer (a start byte address, a byte count, a load/store kind and, for stores, the bytes to be written) and turns it into a run of memory messages, none of which crosses a cache-line boundary. A head chunk runs from the start address up to the end of its line. Each chunk after it is line-aligned and at most one line long. One message is in flight at a time. The next chunk goes out only once the memory side has answered the previous one, with line data for a load or a bare acknowledge for a store.

Load data is gathered into a byte buffer that the surrounding logic reads once the completion pulse fires. Store data is latched at acceptance, and each message carries the matching slice placed in its line lanes. While a transfer runs, the request side is held off. Request kinds other than plain load and store are consumed and flagged as rejected.

Top module: `dma_line_seq`

## Requirements
- R1: A request is taken only while idle (`req_ready_o` high). `busy_o` rises on the cycle after acceptance and stays high until the cycle the completion pulse appears. `req_ready_o` is low for that whole time, and a request presented then is not accepted.
- R2: `req_kind_i` encoding: 0 = load and 1 = store are accepted. Codes 2 to 7 (fetch, locked read, locked write, read-modify-write read, read-modify-write write, none) are rejected, as is a length of 0 or above MAX_LEN. A rejected request leaves `busy_o` low and makes `req_reject_o` high for exactly the next cycle.
- R3: The first message has `msg_addr_o` equal to the start address. Its `msg_len_o` is the smaller of the request length and LINE_BYTES minus the start's offset in the line.
- R4: `msg_line_o` equals `msg_addr_o` with its low log2(LINE_BYTES) bits cleared.
- R5: Each later message has address start + bytes completed, which is line-aligned. Its length is the smaller of the remaining bytes and LINE_BYTES.
- R6: At most one message is outstanding. `msg_valid_o` stays high with stable fields until `msg_ready_i`, then stays low until a response arrives.
- R7: `rsp_valid_i` is ignored while no message awaits a response, whether the block is idle or a message is not yet taken.
- R8: `done_o` is high for one cycle, the cycle after the response that completes the last byte. In that same cycle `busy_o` is low.
- R9: For loads, response line bytes starting at the chunk's line offset (byte j is `rsp_data_i[8j+:8]`) are written to `rdata_o` from position bytes-completed (byte k is `rdata_o[8k+:8]`). `rdata_o` is cleared to zero at acceptance.
- R10: Store messages have `msg_write_o` = 1. Lanes offset .. offset+len-1 of `msg_data_o` carry `req_wdata_i` bytes from position bytes-completed upward (byte k is `req_wdata_i[8k+:8]`). All other lanes are zero. A store response's data is not used.
- R11: Load messages have `msg_write_o` = 0 and an all-zero `msg_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transfer request present |
| req_ready_o | output | 1 | Request consumed this cycle (idle) |
| req_kind_i | input | 3 | Request kind code |
| req_addr_i | input | ADDR_W | Start byte address |
| req_len_i | input | LEN_W | Byte count |
| req_wdata_i | input | MAX_LEN*8 | Store bytes, byte k at [8k+:8] |
| req_reject_o | output | 1 | Pulse: last request refused |
| busy_o | output | 1 | Transfer in progress |
| msg_valid_o | output | 1 | Memory message valid |
| msg_ready_i | input | 1 | Memory side takes message |
| msg_addr_o | output | ADDR_W | Message byte address |
| msg_line_o | output | ADDR_W | Message line address |
| msg_len_o | output | CL_W | Message byte count |
| msg_write_o | output | 1 | Store message |
| msg_data_o | output | LINE_BYTES*8 | Store data in line lanes |
| rsp_valid_i | input | 1 | Response or acknowledge |
| rsp_data_i | input | LINE_BYTES*8 | Line data for loads |
| done_o | output | 1 | Transfer complete pulse |
| rdata_o | output | MAX_LEN*8 | Assembled load bytes |

## Verification
The bench builds the block with 8-byte lines, a 32-byte transfer limit and 16-bit addresses. Short lines make a single request split into four or five chunks. Starts land on offset zero, mid-line and the last byte of a line, and lengths reach exactly to a boundary, stay inside one line or fill the whole 32-byte buffer. The small buffer also brings both length rejections (0 and 33) within reach.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [2:0] {
    KIND_LOAD    = 3'd0,
    KIND_STORE   = 3'd1,
    KIND_FETCH   = 3'd2,
    KIND_LOCK_RD = 3'd3,
    KIND_LOCK_WR = 3'd4,
    KIND_RMW_RD  = 3'd5,
    KIND_RMW_WR  = 3'd6,
    KIND_NONE    = 3'd7
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;

  function automatic logic kind_supported(input logic [2:0] k);
    return (k == KIND_LOAD) || (k == KIND_STORE);
  endfunction

endpackage

// File: rtl/dma_chunk_calc.sv
module dma_chunk_calc #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int LEN_W      = 9,
  parameter int CL_W       = 7
) (
  input  logic [ADDR_W-1:0] start_i,
  input  logic [LEN_W-1:0]  total_i,
  input  logic [LEN_W-1:0]  done_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] line_o,
  output logic [CL_W-2:0]   off_o,
  output logic [CL_W-1:0]   len_o
);
  localparam int OFF_W = CL_W - 1;
  localparam int CW    = ((LEN_W > CL_W) ? LEN_W : CL_W) + 1;

  logic [CW-1:0] room, rem, pick;

  always_comb begin
    addr_o = start_i + ADDR_W'(done_i);
    off_o  = addr_o[OFF_W-1:0];
    line_o = {addr_o[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    room   = CW'(LINE_BYTES) - CW'(off_o);
    rem    = CW'(total_i) - CW'(done_i);
    pick   = (rem < room) ? rem : room;
    len_o  = CL_W'(pick);
  end
endmodule

// File: rtl/dma_wr_slicer.sv
module dma_wr_slicer #(
  parameter int LINE_BYTES = 64,
  parameter int MAX_LEN    = 256,
  parameter int LEN_W      = 9,
  parameter int CL_W       = 7
) (
  input  logic                    en_i,
  input  logic [MAX_LEN*8-1:0]    wbuf_i,
  input  logic [LEN_W-1:0]        pos_i,
  input  logic [CL_W-2:0]         off_i,
  input  logic [CL_W-1:0]         len_i,
  output logic [LINE_BYTES*8-1:0] data_o
);
  for (genvar j = 0; j < LINE_BYTES; j++) begin : g_lane
    int src;
    always_comb begin
      src = int'(pos_i) + j - int'(off_i);
      data_o[j*8 +: 8] = 8'h00;
      if (en_i && j >= int'(off_i) && j < int'(off_i) + int'(len_i) &&
          src >= 0 && src < MAX_LEN)
        data_o[j*8 +: 8] = wbuf_i[src*8 +: 8];
    end
  end
endmodule

// File: rtl/dma_rd_assembler.sv
module dma_rd_assembler #(
  parameter int LINE_BYTES = 64,
  parameter int MAX_LEN    = 256,
  parameter int LEN_W      = 9,
  parameter int CL_W       = 7
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    load_i,
  input  logic [LINE_BYTES*8-1:0] line_i,
  input  logic [CL_W-2:0]         off_i,
  input  logic [CL_W-1:0]         len_i,
  input  logic [LEN_W-1:0]        pos_i,
  output logic [MAX_LEN*8-1:0]    buf_o
);
  for (genvar k = 0; k < MAX_LEN; k++) begin : g_byte
    int         src;
    logic       hit;
    logic [7:0] nxt;
    logic [7:0] byte_q;

    always_comb begin
      src = int'(off_i) + k - int'(pos_i);
      hit = load_i && k >= int'(pos_i) && k < int'(pos_i) + int'(len_i) &&
            src >= 0 && src < LINE_BYTES;
      nxt = hit ? line_i[src*8 +: 8] : byte_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      byte_q <= 8'h00;
      else if (clear_i) byte_q <= 8'h00;
      else              byte_q <= nxt;
    end

    assign buf_o[k*8 +: 8] = byte_q;
  end
endmodule

// File: rtl/dma_line_seq.sv
module dma_line_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_LEN    = 256,
  parameter int LEN_W      = $clog2(MAX_LEN + 1),
  parameter int CL_W       = $clog2(LINE_BYTES) + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [2:0]              req_kind_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [LEN_W-1:0]        req_len_i,
  input  logic [MAX_LEN*8-1:0]    req_wdata_i,
  output logic                    req_reject_o,
  output logic                    busy_o,
  output logic                    msg_valid_o,
  input  logic                    msg_ready_i,
  output logic [ADDR_W-1:0]       msg_addr_o,
  output logic [ADDR_W-1:0]       msg_line_o,
  output logic [CL_W-1:0]         msg_len_o,
  output logic                    msg_write_o,
  output logic [LINE_BYTES*8-1:0] msg_data_o,
  input  logic                    rsp_valid_i,
  input  logic [LINE_BYTES*8-1:0] rsp_data_i,
  output logic                    done_o,
  output logic [MAX_LEN*8-1:0]    rdata_o
);
  localparam int OFF_W = CL_W - 1;

  seq_state_e           state_q;
  logic [ADDR_W-1:0]    start_q;
  logic [LEN_W-1:0]     len_q, completed_q, issued_q;
  logic                 write_q, done_q, reject_q;
  logic [MAX_LEN*8-1:0] wbuf_q;

  logic              idle, len_ok, accept, refuse, last_rsp, rd_load;
  logic [OFF_W-1:0]  chunk_off;
  logic [CL_W-1:0]   chunk_len;
  logic [LINE_BYTES*8-1:0] slice;

  assign idle     = (state_q == ST_IDLE);
  assign len_ok   = (req_len_i != '0) && (int'(req_len_i) <= MAX_LEN);
  assign accept   = idle && req_valid_i && kind_supported(req_kind_i) && len_ok;
  assign refuse   = idle && req_valid_i && !(kind_supported(req_kind_i) && len_ok);
  assign last_rsp = (state_q == ST_WAIT) && rsp_valid_i && (issued_q == len_q);
  assign rd_load  = (state_q == ST_WAIT) && rsp_valid_i && !write_q;

  dma_chunk_calc #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LEN_W(LEN_W), .CL_W(CL_W)
  ) u_calc (
    .start_i(start_q), .total_i(len_q), .done_i(completed_q),
    .addr_o(msg_addr_o), .line_o(msg_line_o), .off_o(chunk_off), .len_o(chunk_len)
  );

  dma_wr_slicer #(
    .LINE_BYTES(LINE_BYTES), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .CL_W(CL_W)
  ) u_slice (
    .en_i(write_q), .wbuf_i(wbuf_q), .pos_i(completed_q),
    .off_i(chunk_off), .len_i(chunk_len), .data_o(slice)
  );

  dma_rd_assembler #(
    .LINE_BYTES(LINE_BYTES), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .CL_W(CL_W)
  ) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(accept), .load_i(rd_load),
    .line_i(rsp_data_i), .off_i(chunk_off), .len_i(chunk_len),
    .pos_i(completed_q), .buf_o(rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      start_q     <= '0;
      len_q       <= '0;
      completed_q <= '0;
      issued_q    <= '0;
      write_q     <= 1'b0;
      wbuf_q      <= '0;
      done_q      <= 1'b0;
      reject_q    <= 1'b0;
    end else begin
      done_q   <= last_rsp;
      reject_q <= refuse;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q     <= ST_SEND;
          start_q     <= req_addr_i;
          len_q       <= req_len_i;
          write_q     <= (req_kind_i == KIND_STORE);
          wbuf_q      <= req_wdata_i;
          completed_q <= '0;
          issued_q    <= '0;
        end
        ST_SEND: if (msg_ready_i) begin
          issued_q <= issued_q + LEN_W'(chunk_len);
          state_q  <= ST_WAIT;
        end
        ST_WAIT: if (rsp_valid_i) begin
          completed_q <= issued_q;
          state_q     <= (issued_q == len_q) ? ST_IDLE : ST_SEND;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = idle;
  assign busy_o       = !idle;
  assign msg_valid_o  = (state_q == ST_SEND);
  assign msg_len_o    = chunk_len;
  assign msg_write_o  = write_q;
  assign msg_data_o   = write_q ? slice : '0;
  assign done_o       = done_q;
  assign req_reject_o = reject_q;

  // R6
  msg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_addr_o) &&
                                    $stable(msg_len_o) && $stable(msg_data_o));
  // R6
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_ready_i |=> !msg_valid_o);
  // R5
  later_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && completed_q != '0 |-> msg_addr_o[OFF_W-1:0] == '0);
  // R3
  len_fits_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> msg_len_o != '0 &&
                    int'(msg_len_o) + int'(msg_addr_o[OFF_W-1:0]) <= LINE_BYTES);
  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
  // R1
  busy_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i) && $past(req_ready_o));
  // R8
  issued_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> issued_q <= len_q);
endmodule

// File: tb/dma_line_seq_test.sv
module dma_line_seq_test;
  localparam int AW = 16;
  localparam int LB = 8;
  localparam int ML = 32;
  localparam int LW = $clog2(ML + 1);
  localparam int CW = $clog2(LB) + 1;
  localparam int NREQ = 14;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [2:0]        req_kind_i = '0;
  logic [AW-1:0]     req_addr_i = '0;
  logic [LW-1:0]     req_len_i = '0;
  logic [ML*8-1:0]   req_wdata_i = '0;
  logic              req_reject_o, busy_o, msg_valid_o;
  logic              msg_ready_i = 1'b0;
  logic [AW-1:0]     msg_addr_o, msg_line_o;
  logic [CW-1:0]     msg_len_o;
  logic              msg_write_o;
  logic [LB*8-1:0]   msg_data_o;
  logic              rsp_valid_i = 1'b0;
  logic [LB*8-1:0]   rsp_data_i = '0;
  logic              done_o;
  logic [ML*8-1:0]   rdata_o;

  dma_line_seq #(.ADDR_W(AW), .LINE_BYTES(LB), .MAX_LEN(ML)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_kind_i(req_kind_i),
    .req_addr_i(req_addr_i), .req_len_i(req_len_i), .req_wdata_i(req_wdata_i),
    .req_reject_o(req_reject_o), .busy_o(busy_o),
    .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i), .msg_addr_o(msg_addr_o),
    .msg_line_o(msg_line_o), .msg_len_o(msg_len_o), .msg_write_o(msg_write_o),
    .msg_data_o(msg_data_o), .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
    .done_o(done_o), .rdata_o(rdata_o)
  );

  int vectors = 0;
  int fails = 0;

  // reference model state: 0 idle, 1 message offered, 2 awaiting response
  int m_phase = 0;
  int m_start, m_len, m_done, m_iss;
  bit m_write;
  logic [7:0] m_wbuf[ML];
  logic [7:0] m_rbuf[ML];
  bit e_done = 0, e_rej = 0;

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int cur_addr();
    return (m_start + m_done) & 16'hFFFF;
  endfunction
  function automatic int cur_off();
    return cur_addr() % LB;
  endfunction
  function automatic int cur_len();
    int a = m_len - m_done;
    int b = LB - cur_off();
    return (a < b) ? a : b;
  endfunction

  function automatic logic [7:0] mem_byte(input int line, input int j);
    return 8'((line / LB) * 13 + j * 29 + 8'h3C);
  endfunction

  task automatic get_req(input int i, output int kind, output int addr, output int len);
    case (i)
      0:  begin kind = 0; addr = 3;  len = 2;  end
      1:  begin kind = 0; addr = 5;  len = 3;  end
      2:  begin kind = 0; addr = 6;  len = 20; end
      3:  begin kind = 1; addr = 0;  len = 16; end
      4:  begin kind = 2; addr = 8;  len = 4;  end
      5:  begin kind = 1; addr = 13; len = 32; end
      6:  begin kind = 5; addr = 0;  len = 8;  end
      7:  begin kind = 0; addr = 16; len = 1;  end
      8:  begin kind = 0; addr = 4;  len = 0;  end
      9:  begin kind = 1; addr = 4;  len = 33; end
      10: begin kind = 0; addr = 7;  len = 32; end
      11: begin kind = 1; addr = 15; len = 1;  end
      12: begin kind = 7; addr = 2;  len = 2;  end
      default: begin kind = 1; addr = 2; len = 9; end
    endcase
  endtask

  task automatic model_step();
    e_done = 0;
    e_rej  = 0;
    case (m_phase)
      0: if (req_valid_i) begin
        if (req_kind_i <= 3'd1 && req_len_i >= 1 && int'(req_len_i) <= ML) begin
          m_phase = 1;
          m_start = int'(req_addr_i);
          m_len   = int'(req_len_i);
          m_write = (req_kind_i == 3'd1);
          m_done  = 0;
          m_iss   = 0;
          for (int k = 0; k < ML; k++) begin
            m_wbuf[k] = req_wdata_i[k*8 +: 8];
            m_rbuf[k] = 8'h00;
          end
        end else e_rej = 1;
      end
      1: if (msg_ready_i) begin
        m_iss   = m_iss + cur_len();
        m_phase = 2;
      end
      default: if (rsp_valid_i) begin
        if (!m_write)
          for (int b = 0; b < cur_len(); b++)
            m_rbuf[m_done + b] = rsp_data_i[(cur_off() + b)*8 +: 8];
        m_done = m_iss;
        if (m_done == m_len) begin
          m_phase = 0;
          e_done  = 1;
        end else m_phase = 1;
      end
    endcase
  endtask

  task automatic compare();
    logic [255:0] rb, wd;
    string at, dt;
    chk("R1 req_ready", 256'(req_ready_o), 256'(m_phase == 0));
    chk("R1 busy", 256'(busy_o), 256'(m_phase != 0));
    chk("R6 msg_valid", 256'(msg_valid_o), 256'(m_phase == 1));
    if (m_phase == 1) begin
      at = (m_done == 0) ? "R3 first addr" : "R5 later addr";
      chk(at, 256'(msg_addr_o), 256'(cur_addr()));
      chk("R4 line addr", 256'(msg_line_o), 256'(cur_addr() - cur_off()));
      chk((m_done == 0) ? "R3 first len" : "R5 later len", 256'(msg_len_o), 256'(cur_len()));
      chk(m_write ? "R10 write flag" : "R11 write flag", 256'(msg_write_o), 256'(m_write));
      wd = '0;
      if (m_write)
        for (int j = 0; j < LB; j++)
          if (j >= cur_off() && j < cur_off() + cur_len())
            wd[j*8 +: 8] = m_wbuf[m_done + j - cur_off()];
      dt = m_write ? "R10 store lanes" : "R11 load data zero";
      chk(dt, 256'(msg_data_o), wd);
    end
    chk("R8 done pulse", 256'(done_o), 256'(e_done));
    chk("R2 reject pulse", 256'(req_reject_o), 256'(e_rej));
    rb = '0;
    for (int k = 0; k < ML; k++) rb[k*8 +: 8] = m_rbuf[k];
    chk("R9 read buffer", rdata_o, rb);
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    int idx = 0;
    int tail = 0;
    int cycles = 0;
    int kind, addr, len;
    for (int k = 0; k < ML; k++) begin m_wbuf[k] = 0; m_rbuf[k] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset ready", 256'(req_ready_o), 256'(1));
    chk("R1 reset busy", 256'(busy_o), 256'(0));
    chk("R6 reset valid", 256'(msg_valid_o), 256'(0));
    chk("R9 reset rdata", rdata_o, '0);
    rst_ni = 1'b1;
    while (tail < 6) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      msg_ready_i = lfsr[0] | lfsr[3];
      // R7: stray responses outside the wait phase
      if (m_phase == 2) begin
        rsp_valid_i = lfsr[1];
        for (int j = 0; j < LB; j++) rsp_data_i[j*8 +: 8] = mem_byte(cur_addr(), j);
      end else begin
        rsp_valid_i = lfsr[5] & lfsr[2];
        rsp_data_i  = {4{lfsr}};
      end
      req_valid_i = 1'b0;
      if (m_phase == 0 && idx < NREQ) begin
        get_req(idx, kind, addr, len);
        req_valid_i = 1'b1;
        req_kind_i  = 3'(kind);
        req_addr_i  = AW'(addr);
        req_len_i   = LW'(len);
        for (int k = 0; k < ML; k++) req_wdata_i[k*8 +: 8] = 8'(idx * 37 + k * 11 + 1);
        idx++;
      end else if (m_phase != 0 && lfsr[4]) begin
        // R1: request while busy must not be taken
        req_valid_i = 1'b1;
        req_kind_i  = 3'd0;
        req_addr_i  = AW'(1);
        req_len_i   = LW'(4);
      end
      @(posedge clk);
      #1;
      model_step();
      @(negedge clk);
      compare();
      if (idx >= NREQ && m_phase == 0) tail++;
      cycles++;
      if (cycles > 20000) begin
        vectors++;
        fails++;
        $display("FAIL watchdog act=%0d exp=<20000 cycles", cycles);
        break;
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule